// File: doc/BRIEF.md
# Linear Ratio Video Decimator

This block shrinks a live luma stream so that it can be shown as an inset picture. Each input line carries up to a fixed number of active samples. Each field carries a fixed number of active lines, and that number depends on the selected frame-rate standard. Two numerators set the scale factors, one horizontal and one vertical. Both are taken over a fixed denominator of 96. The block keeps the matching share of samples and lines by running a linear accumulator in each direction. A zero numerator turns the inset off.

Kept samples of a kept line go into one half of a two-bank line store. When the line closes, the store plays that line back as one unbroken burst. During playback each pixel can be repeated horizontally, and the whole line can be sent twice. In a fixed-ratio playback mode the horizontal numerator is pinned and the vertical numerator snaps to one of three allowed values.

Top module: `ratio_decimator`

## Requirements
- R1: With horizontal numerator h, a line with n valid samples (n at most 1408) yields floor(n*h/96) kept samples. A sample is kept when a running sum, cleared at each line start and increased by h per sample, reaches 96; 96 is then taken off the sum. So h=48 keeps samples 1,3,5,..., giving 704 from 1408, and h=24 keeps samples 3,7,11,..., giving 352.
- R2: Valid samples after the 1408th of a line are ignored.
- R3: Lines are numbered from the first line start after a field start. Only the first 228 lines are active when std_50hz=0, or the first 276 when std_50hz=1. Active line i is kept by the same running-sum rule with vertical numerator v, the sum being cleared at field start. A field therefore yields floor(L*v/96) output lines, where L is the active line count.
- R4: A zero horizontal or vertical numerator produces no output at all.
- R5: A horizontal numerator above 48 acts as 48, and a vertical numerator above 96 acts as 96.
- R6: With fixed_mode=1, any nonzero horizontal numerator acts as 12. A nonzero vertical numerator (after R5) acts as 24 if it is 24 or more, as 16 if it is 16 to 23, and as 12 if it is below 16.
- R7: Horizontal repeat code h_rep: 00 sends each pixel once, 01 twice, 11 four times, and 10 once. The copies of a pixel fill consecutive cycles.
- R8: With v_rep=1 each kept line is played twice. out_sol is high on the first output pixel of every played line and only when out_valid is high.
- R9: Kept pixels come out in input order, as one gap-free burst that starts after the line is closed by the next line start or field start.
- R10: The horizontal numerator is sampled at line start and the vertical numerator at field start. A change between those points has no effect until the next one.
- R11: After reset out_valid is low, and no line is processed until the first field start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| pix_valid | input | 1 | input sample strobe |
| pix_data | input | 8 | input luma sample |
| line_start | input | 1 | one-cycle marker opening a line |
| field_start | input | 1 | one-cycle marker opening a field |
| h_num | input | 6 | horizontal numerator over 96 |
| v_num | input | 7 | vertical numerator over 96 |
| std_50hz | input | 1 | 1 selects 276 active lines, 0 selects 228 |
| fixed_mode | input | 1 | pins numerators to fixed-ratio values |
| h_rep | input | 2 | horizontal pixel repeat code |
| v_rep | input | 1 | send each line twice |
| out_valid | output | 1 | output pixel strobe |
| out_data | output | 8 | output luma pixel |
| out_sol | output | 1 | first pixel of an output line |

## Verification
A wrong accumulator value changes which samples are kept. This shows up as the wrong sample values or counts in the burst after the very next line close. If the line counter or vertical sum drifts, the number of out_sol pulses per field is wrong, and this is visible one field later. A wrong playback counter shows up at once as a broken burst, a missing repeat or a misplaced out_sol inside the next played line.

// File: rtl/rdc_pkg.sv
package rdc_pkg;

    typedef enum logic [1:0] {
        REP_X1  = 2'b00,
        REP_X2  = 2'b01,
        REP_RSV = 2'b10,
        REP_X4  = 2'b11
    } rep_code_e;

    // copies minus one for a horizontal repeat code
    function automatic logic [1:0] rep_extra(input logic [1:0] code);
        case (code)
            REP_X2:  rep_extra = 2'd1;
            REP_X4:  rep_extra = 2'd3;
            default: rep_extra = 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/rdc_clamp.sv
module rdc_clamp #(
    parameter int H_W       = 6,
    parameter int V_W       = 7,
    parameter int H_MAX     = 48,
    parameter int V_MAX     = 96,
    parameter int FIX_H     = 12,
    parameter int FIX_V_HI  = 24,
    parameter int FIX_V_MID = 16,
    parameter int FIX_V_LO  = 12
) (
    input  logic [H_W-1:0] h_raw,
    input  logic [V_W-1:0] v_raw,
    input  logic           fixed_mode,
    output logic [H_W-1:0] h_out,
    output logic [V_W-1:0] v_out
);
    logic [H_W-1:0] h_lim;
    logic [V_W-1:0] v_lim;

    always_comb begin
        h_lim = (h_raw > H_W'(H_MAX)) ? H_W'(H_MAX) : h_raw;
        v_lim = (v_raw > V_W'(V_MAX)) ? V_W'(V_MAX) : v_raw;
        if (!fixed_mode) begin
            h_out = h_lim;
            v_out = v_lim;
        end else begin
            h_out = (h_lim == '0) ? '0 : H_W'(FIX_H);
            if (v_lim == '0)
                v_out = '0;
            else if (v_lim >= V_W'(FIX_V_HI))
                v_out = V_W'(FIX_V_HI);
            else if (v_lim >= V_W'(FIX_V_MID))
                v_out = V_W'(FIX_V_MID);
            else
                v_out = V_W'(FIX_V_LO);
        end
    end
endmodule

// File: rtl/rdc_stepper.sv
module rdc_stepper #(
    parameter int NUM_W = 7,
    parameter int DEN   = 96,
    localparam int ACC_W = $clog2(2 * DEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [NUM_W-1:0] num,
    output logic             hit,
    output logic [ACC_W-1:0] acc
);
    logic [ACC_W-1:0] acc_d, acc_q;
    logic [ACC_W-1:0] base;
    logic [ACC_W-1:0] sum;

    always_comb begin
        base  = clear ? '0 : acc_q;
        sum   = base + ACC_W'(num);
        hit   = step && (sum >= ACC_W'(DEN));
        acc_d = base;
        if (step)
            acc_d = hit ? (sum - ACC_W'(DEN)) : sum;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign acc = acc_q;
endmodule

// File: rtl/rdc_expander.sv
module rdc_expander #(
    parameter int DW    = 8,
    parameter int DEPTH = 704,
    localparam int LW   = $clog2(DEPTH + 1),
    localparam int IW   = $clog2(2 * DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          close,
    input  logic [1:0]    h_rep,
    input  logic          v_rep,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          out_sol
);
    import rdc_pkg::*;

    typedef struct packed {
        logic          wr_bank;
        logic [LW-1:0] wr_ptr;
        logic          pend;
        logic          pend_bank;
        logic [LW-1:0] pend_len;
        logic          busy;
        logic          rd_bank;
        logic [LW-1:0] rd_len;
        logic [LW-1:0] rd_ptr;
        logic [1:0]    hcnt;
        logic          vcnt;
        logic [1:0]    hmax;
        logic          vmax;
        logic          o_valid;
        logic [DW-1:0] o_data;
        logic          o_sol;
    } exp_state_t;

    exp_state_t s_d, s_q;
    logic [DW-1:0] mem [0:2*DEPTH-1];
    logic          do_write;
    logic [IW-1:0] wr_idx;
    logic [IW-1:0] rd_idx;

    always_comb begin
        s_d      = s_q;
        do_write = wr_en && (s_q.wr_ptr < LW'(DEPTH));
        wr_idx   = s_q.wr_bank ? IW'(DEPTH) + IW'(s_q.wr_ptr) : IW'(s_q.wr_ptr);
        rd_idx   = s_q.rd_bank ? IW'(DEPTH) + IW'(s_q.rd_ptr) : IW'(s_q.rd_ptr);

        if (do_write)
            s_d.wr_ptr = s_q.wr_ptr + 1'b1;

        // playback side
        s_d.o_valid = 1'b0;
        s_d.o_sol   = 1'b0;
        if (s_q.busy) begin
            s_d.o_valid = 1'b1;
            s_d.o_data  = mem[rd_idx];
            s_d.o_sol   = (s_q.rd_ptr == '0) && (s_q.hcnt == '0);
            if (s_q.hcnt == s_q.hmax) begin
                s_d.hcnt = '0;
                if (s_q.rd_ptr == s_q.rd_len - 1'b1) begin
                    s_d.rd_ptr = '0;
                    if (s_q.vcnt == s_q.vmax) begin
                        s_d.busy = 1'b0;
                        s_d.vcnt = 1'b0;
                    end else begin
                        s_d.vcnt = 1'b1;
                    end
                end else begin
                    s_d.rd_ptr = s_q.rd_ptr + 1'b1;
                end
            end else begin
                s_d.hcnt = s_q.hcnt + 1'b1;
            end
        end else if (s_q.pend) begin
            s_d.pend    = 1'b0;
            s_d.busy    = 1'b1;
            s_d.rd_bank = s_q.pend_bank;
            s_d.rd_len  = s_q.pend_len;
            s_d.rd_ptr  = '0;
            s_d.hcnt    = '0;
            s_d.vcnt    = 1'b0;
            s_d.hmax    = rep_extra(h_rep);
            s_d.vmax    = v_rep;
        end

        // line close hands the filled bank to playback
        if (close) begin
            if (s_q.wr_ptr != '0) begin
                s_d.pend      = 1'b1;
                s_d.pend_bank = s_q.wr_bank;
                s_d.pend_len  = s_q.wr_ptr;
                s_d.wr_bank   = ~s_q.wr_bank;
            end
            s_d.wr_ptr = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (do_write) mem[wr_idx] <= wr_data;
    end

    assign out_valid = s_q.o_valid;
    assign out_data  = s_q.o_data;
    assign out_sol   = s_q.o_sol;
endmodule

// File: rtl/ratio_decimator.sv
module ratio_decimator #(
    parameter int DW       = 8,
    parameter int H_W      = 6,
    parameter int V_W      = 7,
    parameter int DEN      = 96,
    parameter int H_MAX    = 48,
    parameter int V_MAX    = 96,
    parameter int ACT_PIX  = 1408,
    parameter int LINES_60 = 228,
    parameter int LINES_50 = 276,
    parameter int FIX_H    = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pix_valid,
    input  logic [DW-1:0]  pix_data,
    input  logic           line_start,
    input  logic           field_start,
    input  logic [H_W-1:0] h_num,
    input  logic [V_W-1:0] v_num,
    input  logic           std_50hz,
    input  logic           fixed_mode,
    input  logic [1:0]     h_rep,
    input  logic           v_rep,
    output logic           out_valid,
    output logic [DW-1:0]  out_data,
    output logic           out_sol
);
    localparam int DEPTH = ACT_PIX * H_MAX / DEN;
    localparam int LC_W  = $clog2(LINES_50 + 1);
    localparam int PC_W  = $clog2(ACT_PIX + 1);
    localparam int ACC_W = $clog2(2 * DEN);

    typedef struct packed {
        logic            in_field;
        logic            line_kept;
        logic [LC_W-1:0] line_cnt;
        logic [PC_W-1:0] pix_cnt;
        logic [H_W-1:0]  h_num;
        logic [V_W-1:0]  v_num;
    } top_state_t;

    top_state_t s_d, s_q;

    logic [H_W-1:0]  h_cond;
    logic [V_W-1:0]  v_cond;
    logic [V_W-1:0]  v_use;
    logic [LC_W-1:0] base_cnt;
    logic [LC_W-1:0] lim;
    logic            base_field;
    logic            v_step, v_hit, h_step, h_hit;
    logic            close_line, wr_en;
    logic [ACC_W-1:0] h_acc, v_acc;

    rdc_clamp #(
        .H_W(H_W), .V_W(V_W), .H_MAX(H_MAX), .V_MAX(V_MAX), .FIX_H(FIX_H)
    ) u_clamp (
        .h_raw(h_num), .v_raw(v_num), .fixed_mode(fixed_mode),
        .h_out(h_cond), .v_out(v_cond)
    );

    rdc_stepper #(.NUM_W(V_W), .DEN(DEN)) u_vstep (
        .clk(clk), .rst_n(rst_n), .clear(field_start), .step(v_step),
        .num(v_use), .hit(v_hit), .acc(v_acc)
    );

    rdc_stepper #(.NUM_W(H_W), .DEN(DEN)) u_hstep (
        .clk(clk), .rst_n(rst_n), .clear(line_start), .step(h_step),
        .num(s_q.h_num), .hit(h_hit), .acc(h_acc)
    );

    always_comb begin
        s_d        = s_q;
        v_step     = 1'b0;
        h_step     = 1'b0;
        wr_en      = 1'b0;
        close_line = line_start | field_start;
        base_cnt   = field_start ? '0 : s_q.line_cnt;
        base_field = field_start | s_q.in_field;
        v_use      = field_start ? v_cond : s_q.v_num;
        lim        = std_50hz ? LC_W'(LINES_50) : LC_W'(LINES_60);

        if (field_start) begin
            s_d.in_field  = 1'b1;
            s_d.line_cnt  = '0;
            s_d.v_num     = v_cond;
            s_d.line_kept = 1'b0;
        end

        if (line_start) begin
            s_d.pix_cnt = '0;
            s_d.h_num   = h_cond;
            if (base_field && (base_cnt < lim)) begin
                v_step        = 1'b1;
                s_d.line_cnt  = base_cnt + 1'b1;
                s_d.line_kept = v_hit;
            end else begin
                s_d.line_kept = 1'b0;
            end
        end else if (!field_start && pix_valid && s_q.line_kept &&
                     (s_q.pix_cnt < PC_W'(ACT_PIX))) begin
            h_step      = 1'b1;
            s_d.pix_cnt = s_q.pix_cnt + 1'b1;
            wr_en       = h_hit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    rdc_expander #(.DW(DW), .DEPTH(DEPTH)) u_exp (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(pix_data),
        .close(close_line), .h_rep(h_rep), .v_rep(v_rep),
        .out_valid(out_valid), .out_data(out_data), .out_sol(out_sol)
    );

    // plain views of state for the bound checker
    logic [H_W-1:0]  chk_h_num;
    logic [V_W-1:0]  chk_v_num;
    logic [LC_W-1:0] chk_line_cnt;
    logic            chk_kept;
    logic            chk_field;
    logic [ACC_W-1:0] chk_h_acc;
    logic [ACC_W-1:0] chk_v_acc;
    assign chk_h_num    = s_q.h_num;
    assign chk_v_num    = s_q.v_num;
    assign chk_line_cnt = s_q.line_cnt;
    assign chk_kept     = s_q.line_kept;
    assign chk_field    = s_q.in_field;
    assign chk_h_acc    = h_acc;
    assign chk_v_acc    = v_acc;
endmodule

// File: rtl/ratio_decimator_chk.sv
module ratio_decimator_chk #(
    parameter int H_W      = 6,
    parameter int V_W      = 7,
    parameter int DEN      = 96,
    parameter int H_MAX    = 48,
    parameter int V_MAX    = 96,
    parameter int LINES_50 = 276,
    parameter int LC_W     = 9,
    parameter int ACC_W    = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             line_start,
    input logic             out_valid,
    input logic             out_sol,
    input logic [H_W-1:0]   h_num_q,
    input logic [V_W-1:0]   v_num_q,
    input logic [LC_W-1:0]  line_cnt_q,
    input logic             kept_q,
    input logic             field_q,
    input logic [ACC_W-1:0] h_acc,
    input logic [ACC_W-1:0] v_acc
);
    AST_HNUM_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        h_num_q <= H_W'(H_MAX));                                  // R5
    AST_VNUM_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        v_num_q <= V_W'(V_MAX));                                  // R5
    AST_HACC_BELOW_DEN: assert property (@(posedge clk) disable iff (!rst_n)
        h_acc < ACC_W'(DEN));                                     // R1
    AST_VACC_BELOW_DEN: assert property (@(posedge clk) disable iff (!rst_n)
        v_acc < ACC_W'(DEN));                                     // R3
    AST_LINE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        line_cnt_q <= LC_W'(LINES_50));                           // R3
    AST_KEPT_NEEDS_VNUM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(kept_q) |-> (v_num_q != '0));                       // R4
    AST_HNUM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !line_start |=> $stable(h_num_q));                        // R10
    AST_SOL_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_sol |-> out_valid);                                   // R8
    AST_QUIET_BEFORE_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        !field_q |-> !out_valid);                                 // R11
endmodule

bind ratio_decimator ratio_decimator_chk #(
    .H_W(H_W), .V_W(V_W), .DEN(DEN), .H_MAX(H_MAX), .V_MAX(V_MAX),
    .LINES_50(LINES_50), .LC_W(LC_W), .ACC_W(ACC_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .line_start(line_start),
    .out_valid(out_valid), .out_sol(out_sol),
    .h_num_q(chk_h_num), .v_num_q(chk_v_num), .line_cnt_q(chk_line_cnt),
    .kept_q(chk_kept), .field_q(chk_field), .h_acc(chk_h_acc), .v_acc(chk_v_acc)
);

// File: tb/ratio_decimator_bench.sv
`timescale 1ns/1ps
module ratio_decimator_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pix_valid = 1'b0;
    logic [7:0] pix_data = '0;
    logic       line_start = 1'b0;
    logic       field_start = 1'b0;
    logic [5:0] h_num = '0;
    logic [6:0] v_num = '0;
    logic       std_50hz = 1'b0;
    logic       fixed_mode = 1'b0;
    logic [1:0] h_rep = 2'b00;
    logic       v_rep = 1'b0;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_sol;

    always #5 clk = ~clk;

    ratio_decimator u_ratio_decimator (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
        .line_start(line_start), .field_start(field_start),
        .h_num(h_num), .v_num(v_num), .std_50hz(std_50hz),
        .fixed_mode(fixed_mode), .h_rep(h_rep), .v_rep(v_rep),
        .out_valid(out_valid), .out_data(out_data), .out_sol(out_sol)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int cap_n = 0;
    int sol_n = 0;
    logic [7:0] cap_d [0:8191];
    int         cap_t [0:8191];
    logic       cap_s [0:8191];

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (out_valid) begin
            cap_d[cap_n % 8192] <= out_data;
            cap_t[cap_n % 8192] <= cyc;
            cap_s[cap_n % 8192] <= out_sol;
            cap_n <= cap_n + 1;
        end
        if (out_sol) sol_n <= sol_n + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_field();
        @(negedge clk); field_start = 1'b1;
        @(negedge clk); field_start = 1'b0;
    endtask

    task automatic send_line(input int n, input int gap);
        @(negedge clk); line_start = 1'b1;
        @(negedge clk); line_start = 1'b0;
        for (int i = 0; i < n; i++) begin
            pix_valid = 1'b1;
            pix_data  = 8'(i);
            @(negedge clk);
        end
        pix_valid = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    // one line of n samples at numerator hn, keeping every k-th sample
    task automatic run_hline(input int hn, input int n, input int expn,
                             input int stride, input string req);
        int start;
        int bad;
        h_num = 6'(hn); v_num = 7'd96; std_50hz = 1'b0;
        pulse_field();
        start = cap_n;
        send_line(n, 0);
        send_line(0, 720);
        check(cap_n - start == expn, req, cap_n - start, expn);
        bad = 0;
        for (int k = 0; k < expn && k < cap_n - start; k++)
            if (cap_d[(start + k) % 8192] != 8'(stride * k + stride - 1)) bad++;
        check(bad == 0, req, bad, 0);
    endtask

    task automatic test_reset();
        check(out_valid == 1'b0, "R11", int'(out_valid), 0);
        h_num = 6'd48; v_num = 7'd96;
        send_line(8, 2); send_line(8, 2); send_line(0, 10);
        check(cap_n == 0, "R11", cap_n, 0);
    endtask

    task automatic test_clamp_h();
        int start;
        h_num = 6'd63; v_num = 7'd96;
        pulse_field();
        start = cap_n;
        send_line(1408, 0); send_line(0, 720);
        check(cap_n - start == 704, "R5", cap_n - start, 704);
    endtask

    task automatic test_overlong();
        int start;
        h_num = 6'd48; v_num = 7'd96;
        pulse_field();
        start = cap_n;
        send_line(1500, 0); send_line(0, 720);
        check(cap_n - start == 704, "R2", cap_n - start, 704);
    endtask

    task automatic run_field(input int hn, input int vn, input bit s50, input int lines,
                             input int spl, input int exp_lines, input int exp_pix,
                             input string req);
        int start;
        int s0;
        h_num = 6'(hn); v_num = 7'(vn); std_50hz = s50;
        pulse_field();
        start = cap_n; s0 = sol_n;
        for (int l = 0; l < lines; l++) send_line(spl, 4);
        send_line(0, 20);
        check(sol_n - s0 == exp_lines, req, sol_n - s0, exp_lines);
        check(cap_n - start == exp_pix, req, cap_n - start, exp_pix);
    endtask

    task automatic test_zero();
        int start;
        h_num = 6'd0; v_num = 7'd96;
        pulse_field();
        start = cap_n;
        send_line(1408, 0); send_line(0, 20);
        check(cap_n == start, "R4", cap_n - start, 0);
        run_field(48, 0, 1'b0, 6, 8, 0, 0, "R4");
    endtask

    task automatic test_fixed();
        int start;
        fixed_mode = 1'b1;
        // v 20 snaps to 16, h 40 pins to 12: one sample (index 7) per 8
        run_field(40, 20, 1'b0, 230, 8, 38, 38, "R6");
        // v 100 clamps to 96 then snaps to 24: line 3 is first kept
        h_num = 6'd5; v_num = 7'd100; std_50hz = 1'b0;
        pulse_field();
        send_line(0, 0); send_line(0, 0); send_line(0, 0);
        start = cap_n;
        send_line(1408, 0); send_line(0, 300);
        check(cap_n - start == 176, "R6", cap_n - start, 176);
        fixed_mode = 1'b0;
    endtask

    task automatic run_rep(input bit [1:0] code, input bit vr, input int copies,
                           input string req);
        int start;
        int s0;
        int total;
        int bad;
        h_rep = code; v_rep = vr;
        h_num = 6'd24; v_num = 7'd96; std_50hz = 1'b0;
        pulse_field();
        start = cap_n; s0 = sol_n;
        send_line(8, 0); send_line(0, 40);
        total = 2 * copies * (vr ? 2 : 1);
        check(cap_n - start == total, req, cap_n - start, total);
        bad = 0;
        for (int k = 0; k < total && k < cap_n - start; k++) begin
            if (cap_d[(start + k) % 8192] != (((k % (2 * copies)) < copies) ? 8'd3 : 8'd7)) bad++;
            if (cap_s[(start + k) % 8192] != ((k % (2 * copies)) == 0)) bad++;
        end
        check(bad == 0, req, bad, 0);
        if (cap_n - start == total)
            check(cap_t[(start + total - 1) % 8192] - cap_t[start % 8192] == total - 1,
                  "R9", cap_t[(start + total - 1) % 8192] - cap_t[start % 8192], total - 1);
        check(sol_n - s0 == (vr ? 2 : 1), "R8", sol_n - s0, vr ? 2 : 1);
        h_rep = 2'b00; v_rep = 1'b0;
    endtask

    task automatic test_latch();
        int start;
        h_num = 6'd48; v_num = 7'd96;
        pulse_field();
        start = cap_n;
        @(negedge clk); line_start = 1'b1;
        @(negedge clk); line_start = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (i == 4) h_num = 6'd0;
            pix_valid = 1'b1; pix_data = 8'(i);
            @(negedge clk);
        end
        pix_valid = 1'b0;
        send_line(8, 0);
        send_line(0, 20);
        check(cap_n - start == 4, "R10", cap_n - start, 4);
        if (cap_n - start >= 4)
            check(cap_d[(start + 3) % 8192] == 8'd7, "R10", int'(cap_d[(start + 3) % 8192]), 7);
    endtask

    bit done = 1'b0;

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        run_hline(48, 1408, 704, 2, "R1");
        run_hline(24, 1408, 352, 4, "R1");
        begin
            int start;
            h_num = 6'd7; v_num = 7'd96; pulse_field();
            start = cap_n; send_line(1408, 0); send_line(0, 300);
            check(cap_n - start == 1408 * 7 / 96, "R1", cap_n - start, 1408 * 7 / 96);
        end
        test_clamp_h();
        test_overlong();
        run_field(48, 48, 1'b0, 240, 4, 114, 228, "R3");
        run_field(48, 96, 1'b1, 300, 4, 276, 552, "R3");
        run_field(48, 127, 1'b0, 240, 4, 228, 456, "R5");
        test_zero();
        test_fixed();
        run_rep(2'b01, 1'b1, 2, "R7");
        run_rep(2'b11, 1'b0, 4, "R7");
        run_rep(2'b10, 1'b0, 1, "R7");
        test_latch();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule